// File: doc/BRIEF.md
# Dual SRAM Buffer Serial Port

This block is the serial front end for a pair of 264-byte SRAM staging buffers. It works as an SPI slave in mode 0, with SI sampled on the rising edge of SCK and SO changed on the falling edge. It takes the command byte, looks at its bit pattern to choose a buffer and a direction, and skips the filler bits. It then loads a 9-bit start address and streams bytes into the chosen buffer or out of it. Bits travel most significant first. The byte address steps after every byte. When it passes the last byte (263), it wraps to byte 0 of the same buffer.

A read frame has 8 filler bits after the address, which gives the slave time to fetch the first byte. A write frame has no such filler: data starts right after the address. Raising chip select ends any frame. A page-program engine beside the block can read either buffer through a separate registered port. That port does not disturb serial traffic.

The serial pins are oversampled by the block clock. SO is given as a value plus an output enable, so the pad can tri-state it.

Top module: `dfb_buffer_port`

## Requirements
- R1: After reset, and whenever cs_ni is high, so_oe_o is 0 (SO tri-stated).
- R2: Command byte 0x54 or 0xD4 reads buffer 0. Command byte 0x56 or 0xD6 reads buffer 1.
- R3: Command byte 0x84 writes buffer 0. Command byte 0x87 writes buffer 1.
- R4: A read frame is 8 command bits, then 15 ignored bits, then a 9-bit start address, then 8 ignored bits. After that, SO carries the addressed byte MSB first, valid before each SCK rising edge.
- R5: A write frame is 8 command bits, then 15 ignored bits, then a 9-bit start address. Data bytes follow at once, MSB first, and each complete byte is stored at the current address.
- R6: During a read or a write, the address steps by one per byte. After byte 263 it continues at byte 0 of the same buffer.
- R7: A rising cs_ni ends the frame and tri-states SO. If a write byte has fewer than 8 bits when cs_ni rises, that byte is discarded.
- R8: Any other command byte leaves SO tri-stated for the rest of the frame and writes nothing.
- R9: The side port returns, one clock later on pg_data_o, the byte at pg_addr_i of the buffer chosen by pg_sel_i (0 or 1).
- R10: While SO is driven, its value changes only after an SCK falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out value |
| so_oe_o | output | 1 | Output enable for SO |
| pg_sel_i | input | 1 | Side port buffer select |
| pg_addr_i | input | 9 | Side port byte address |
| pg_data_o | output | 8 | Side port read data, one cycle latency |

## Verification
The assertions assume the following about the inputs:
- cs_ni, sck_i and si_i are already synchronous to clk_i.
- Each SCK level lasts at least two clock cycles.
- cs_ni changes only while SCK is low.
- Start addresses stay below 264.

The stimulus holds every SCK level for four clocks and drives inputs on the falling edge of the block clock. It moves chip select only with SCK low and uses addresses from 0 to 263 only. The wrap checks start near the top of each buffer, so they cross byte 263 within a few bytes.

// File: rtl/dfb_pkg.sv
package dfb_pkg;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADR,
    PH_PAD,
    PH_DAT,
    PH_SKIP
  } phase_e;

  typedef struct packed {
    logic valid;
    logic is_rd;
    logic sel;
  } cmd_t;

  localparam logic [7:0] OP_RD0_A = 8'h54;
  localparam logic [7:0] OP_RD0_B = 8'hD4;
  localparam logic [7:0] OP_RD1_A = 8'h56;
  localparam logic [7:0] OP_RD1_B = 8'hD6;
  localparam logic [7:0] OP_WR0   = 8'h84;
  localparam logic [7:0] OP_WR1   = 8'h87;

  function automatic cmd_t decode_op(input logic [7:0] op);
    cmd_t c;
    c = '0;
    unique case (op)
      OP_RD0_A, OP_RD0_B: c = '{valid: 1'b1, is_rd: 1'b1, sel: 1'b0};
      OP_RD1_A, OP_RD1_B: c = '{valid: 1'b1, is_rd: 1'b1, sel: 1'b1};
      OP_WR0:             c = '{valid: 1'b1, is_rd: 1'b0, sel: 1'b0};
      OP_WR1:             c = '{valid: 1'b1, is_rd: 1'b0, sel: 1'b1};
      default:            c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/dfb_sck_edge.sv
module dfb_sck_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  output logic rise_o,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_q <= 1'b0;
    else         sck_q <= sck_i;
  end

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;
endmodule

// File: rtl/dfb_frame_ctl.sv
module dfb_frame_ctl
  import dfb_pkg::*;
#(
  parameter int BUF_BYTES = 264,
  parameter int HDR_PAD   = 15,
  parameter int RD_PAD    = 8,
  localparam int ADDR_W   = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              si_i,
  input  logic              rise_i,
  output logic              wr_en_o,
  output logic              sel_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        wr_data_o,
  output logic [2:0]        bit_idx_o,
  output logic              rd_active_o
);
  localparam int ADR_BITS = HDR_PAD + ADDR_W;
  localparam int CNT_W    = $clog2(ADR_BITS + RD_PAD + 9);

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              is_rd_q, sel_q;
  logic [7:0]        sh_nxt;
  cmd_t              cmd;
  logic              byte_done;

  assign sh_nxt    = {sh_q[6:0], si_i};
  assign cmd       = decode_op(sh_nxt);
  assign byte_done = (cnt_q[2:0] == 3'd7);

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(BUF_BYTES - 1)) ? '0 : a + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_OPC;
      cnt_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      is_rd_q <= 1'b0;
      sel_q   <= 1'b0;
    end else if (cs_ni) begin
      ph_q  <= PH_OPC;
      cnt_q <= '0;
    end else if (rise_i) begin
      unique case (ph_q)
        PH_OPC: begin
          sh_q  <= sh_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (byte_done) begin
            cnt_q   <= '0;
            is_rd_q <= cmd.is_rd;
            sel_q   <= cmd.sel;
            ph_q    <= cmd.valid ? PH_ADR : PH_SKIP;
          end
        end
        PH_ADR: begin
          addr_q <= {addr_q[ADDR_W-2:0], si_i};
          cnt_q  <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ADR_BITS - 1)) begin
            cnt_q <= '0;
            ph_q  <= is_rd_q ? PH_PAD : PH_DAT;
          end
        end
        PH_PAD: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(RD_PAD - 1)) begin
            cnt_q <= '0;
            ph_q  <= PH_DAT;
          end
        end
        PH_DAT: begin
          sh_q  <= sh_nxt;
          cnt_q <= byte_done ? '0 : cnt_q + 1'b1;
          if (byte_done) addr_q <= step(addr_q);
        end
        default: ph_q <= PH_SKIP;
      endcase
    end
  end

  // store only on the eighth rising edge of a byte
  assign wr_en_o     = ~cs_ni & rise_i & (ph_q == PH_DAT) & ~is_rd_q & byte_done;
  assign wr_data_o   = sh_nxt;
  assign sel_o       = sel_q;
  assign addr_o      = addr_q;
  assign bit_idx_o   = cnt_q[2:0];
  assign rd_active_o = ~cs_ni & (ph_q == PH_DAT) & is_rd_q;
endmodule

// File: rtl/dfb_buf_bank.sv
module dfb_buf_bank #(
  parameter int BUF_BYTES = 264,
  parameter int NUM_BUFS  = 2,
  localparam int ADDR_W   = $clog2(BUF_BYTES),
  localparam int SEL_W    = (NUM_BUFS > 1) ? $clog2(NUM_BUFS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [SEL_W-1:0]  sh_sel_i,
  input  logic [ADDR_W-1:0] sh_addr_i,
  output logic [7:0]        sh_data_o,
  input  logic [SEL_W-1:0]  pg_sel_i,
  input  logic [ADDR_W-1:0] pg_addr_i,
  output logic [7:0]        pg_data_o
);
  logic [7:0] sh_word [NUM_BUFS];
  logic [7:0] pg_word [NUM_BUFS];

  for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
    logic [7:0] mem [BUF_BYTES];

    always_ff @(posedge clk_i) begin
      if (wr_en_i && (wr_sel_i == SEL_W'(g)) && (wr_addr_i < ADDR_W'(BUF_BYTES)))
        mem[wr_addr_i] <= wr_data_i;
    end

    assign sh_word[g] = mem[sh_addr_i];
    assign pg_word[g] = mem[pg_addr_i];
  end

  assign sh_data_o = sh_word[sh_sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pg_data_o <= '0;
    else         pg_data_o <= pg_word[pg_sel_i];
  end
endmodule

// File: rtl/dfb_buffer_port.sv
module dfb_buffer_port #(
  parameter int BUF_BYTES = 264,
  parameter int HDR_PAD   = 15,
  parameter int RD_PAD    = 8,
  localparam int ADDR_W   = $clog2(BUF_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  output logic              so_oe_o,
  input  logic              pg_sel_i,
  input  logic [ADDR_W-1:0] pg_addr_i,
  output logic [7:0]        pg_data_o
);
  logic              rise, fall;
  logic              wr_en, sel, rd_active;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wr_data, sh_byte;
  logic [2:0]        bit_idx;
  logic              so_q;

  dfb_sck_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  dfb_frame_ctl #(
    .BUF_BYTES (BUF_BYTES),
    .HDR_PAD   (HDR_PAD),
    .RD_PAD    (RD_PAD)
  ) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .si_i        (si_i),
    .rise_i      (rise),
    .wr_en_o     (wr_en),
    .sel_o       (sel),
    .addr_o      (addr),
    .wr_data_o   (wr_data),
    .bit_idx_o   (bit_idx),
    .rd_active_o (rd_active)
  );

  dfb_buf_bank #(
    .BUF_BYTES (BUF_BYTES),
    .NUM_BUFS  (2)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_sel_i  (sel),
    .wr_addr_i (addr),
    .wr_data_i (wr_data),
    .sh_sel_i  (sel),
    .sh_addr_i (addr),
    .sh_data_o (sh_byte),
    .pg_sel_i  (pg_sel_i),
    .pg_addr_i (pg_addr_i),
    .pg_data_o (pg_data_o)
  );

  // SO moves on SCK fall so the host samples a settled bit on the rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                so_q <= 1'b0;
    else if (fall && rd_active) so_q <= sh_byte[3'd7 - bit_idx];
  end

  assign so_oe_o = rd_active;
  assign so_o    = so_q & rd_active;
endmodule

// File: rtl/dfb_buffer_port_chk.sv
module dfb_buffer_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_ni,
  input logic sck_i,
  input logic so_o,
  input logic so_oe_o,
  input logic wr_en
);
  // R1 / R7: deselected means undriven
  p_so_hiz_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !so_oe_o);

  // R10: a driven SO value moves only right after SCK went low
  p_so_fall_only_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (so_oe_o && $past(so_oe_o) && (so_o != $past(so_o))) |-> !$past(sck_i));

  // R4: output phase opens on a rising SCK with chip selected
  p_oe_rise_on_sck_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(so_oe_o) |-> ($past(sck_i) && !cs_ni));

  // R5: a store never coincides with driving SO
  p_no_write_while_driving_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !so_oe_o);

  // R3 / R7: stores happen only on a selected SCK high
  p_write_on_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> (sck_i && !cs_ni));
endmodule

bind dfb_buffer_port dfb_buffer_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .cs_ni   (cs_ni),
  .sck_i   (sck_i),
  .so_o    (so_o),
  .so_oe_o (so_oe_o),
  .wr_en   (wr_en)
);

// File: tb/dfb_buffer_port_test.sv
module dfb_buffer_port_test;
  localparam int BYTES = 264;
  localparam int HALF  = 4;

  typedef struct packed {
    logic [7:0] wr_op;
    logic [7:0] rd_op;
    logic [8:0] addr;
    logic [7:0] seed;
    logic [3:0] len;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{wr_op: 8'h84, rd_op: 8'h54, addr: 9'd0,   seed: 8'h11, len: 4'd4},
    '{wr_op: 8'h87, rd_op: 8'h56, addr: 9'd100, seed: 8'hA0, len: 4'd3},
    '{wr_op: 8'h84, rd_op: 8'hD4, addr: 9'd262, seed: 8'hC3, len: 4'd4},
    '{wr_op: 8'h87, rd_op: 8'hD6, addr: 9'd5,   seed: 8'h5A, len: 4'd2},
    '{wr_op: 8'h84, rd_op: 8'h54, addr: 9'd10,  seed: 8'hF0, len: 4'd3},
    '{wr_op: 8'h87, rd_op: 8'h56, addr: 9'd263, seed: 8'h7E, len: 4'd2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  logic pg_sel = 1'b0;
  logic [8:0] pg_addr = '0;
  logic [7:0] pg_data;

  int n_chk = 0, n_bad = 0;
  logic oe_seen;
  logic [7:0] model [2][BYTES];

  always #10 clk = ~clk;

  dfb_buffer_port uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cs_ni     (cs_n),
    .sck_i     (sck),
    .si_i      (si),
    .so_o      (so),
    .so_oe_o   (so_oe),
    .pg_sel_i  (pg_sel),
    .pg_addr_i (pg_addr),
    .pg_data_o (pg_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic b, output logic r);
    si = b;
    repeat (HALF) @(negedge clk);
    r = so;
    oe_seen = oe_seen | so_oe;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic xfer_byte(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) xfer_bit(d[i], r[i]);
  endtask

  task automatic frame_open();
    @(negedge clk);
    cs_n = 1'b0;
    oe_seen = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_close();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send_head(input logic [7:0] op, input logic [8:0] a);
    logic [7:0] r;
    logic [23:0] w;
    w = {15'd0, a};
    xfer_byte(op, r);
    xfer_byte(w[23:16], r);
    xfer_byte(w[15:8], r);
    xfer_byte(w[7:0], r);
  endtask

  function automatic int sel_of(input logic [7:0] op);
    return (op == 8'h87 || op == 8'h56 || op == 8'hD6) ? 1 : 0;
  endfunction

  function automatic logic [8:0] nxt(input logic [8:0] a);
    return (a == 9'(BYTES - 1)) ? 9'd0 : a + 9'd1;
  endfunction

  task automatic do_write(input logic [7:0] op, input logic [8:0] a0,
                          input logic [7:0] seed, input int len);
    logic [7:0] r;
    logic [8:0] a;
    a = a0;
    frame_open();
    send_head(op, a0);
    for (int i = 0; i < len; i++) begin
      xfer_byte(seed + 8'(i), r);
      model[sel_of(op)][a] = seed + 8'(i);
      a = nxt(a);
    end
    frame_close();
  endtask

  task automatic do_read(input logic [7:0] op, input logic [8:0] a0,
                         input int len, input string req);
    logic [7:0] r;
    logic [8:0] a;
    a = a0;
    frame_open();
    send_head(op, a0);
    xfer_byte(8'h00, r);
    for (int i = 0; i < len; i++) begin
      xfer_byte(8'h00, r);
      check(req, {24'd0, r}, {24'd0, model[sel_of(op)][a]});
      a = nxt(a);
    end
    frame_close();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [7:0] r;
    logic b;
    repeat (3) @(negedge clk);
    check("R1 reset oe", {31'd0, so_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle oe", {31'd0, so_oe}, 32'd0);

    // table: write then read back (R2 R3 R4 R5 R6)
    for (int v = 0; v < 6; v++) begin
      do_write(VEC[v].wr_op, VEC[v].addr, VEC[v].seed, int'(VEC[v].len));
      do_read(VEC[v].rd_op, VEC[v].addr, int'(VEC[v].len), "R2 R4 R5 R6 readback");
    end

    // R2: buffers kept apart at the same address
    do_read(8'h54, 9'd0, 1, "R2 buffer 0 byte 0");
    do_read(8'hD6, 9'd0, 1, "R2 buffer 1 byte 0");
    check("R6 wrap seed buf1", {24'd0, model[1][0]}, 32'h7F);

    // R7: partial byte dropped
    frame_open();
    send_head(8'h84, 9'd2);
    xfer_byte(8'hAA, r);
    model[0][2] = 8'hAA;
    for (int i = 0; i < 4; i++) xfer_bit(1'b0, b);
    frame_close();
    do_read(8'h54, 9'd2, 2, "R7 partial byte");
    check("R7 byte3 kept", {24'd0, model[0][3]}, 32'h14);

    // R8: unknown command writes nothing, SO stays off
    frame_open();
    send_head(8'h85, 9'd0);
    xfer_byte(8'hFF, r);
    xfer_byte(8'hFF, r);
    xfer_byte(8'hFF, r);
    check("R8 oe during unknown", {31'd0, oe_seen}, 32'd0);
    frame_close();
    do_read(8'h54, 9'd0, 2, "R8 contents unchanged");

    // R7: cs high mid read tri-states SO
    frame_open();
    send_head(8'h56, 9'd100);
    xfer_byte(8'h00, r);
    xfer_byte(8'h00, r);
    check("R4 first read byte", {24'd0, r}, {24'd0, model[1][100]});
    check("R7 oe while reading", {31'd0, so_oe}, 32'd1);
    cs_n = 1'b1;
    @(negedge clk);
    check("R7 oe after cs high", {31'd0, so_oe}, 32'd0);
    repeat (2 * HALF) @(negedge clk);

    // R9: side port
    pg_sel = 1'b1;
    pg_addr = 9'd101;
    repeat (2) @(negedge clk);
    check("R9 side buf1", {24'd0, pg_data}, {24'd0, model[1][101]});
    pg_sel = 1'b0;
    pg_addr = 9'd263;
    repeat (2) @(negedge clk);
    check("R9 side buf0", {24'd0, pg_data}, {24'd0, model[0][263]});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule